// File: doc/BRIEF.md
# Real-Time Counter with Alarm and Periodic Tick

This peripheral keeps a 40-bit free-running time count that advances once per 32.768 kHz tick enable, so the whole-second value is the count shifted right by 15. A 40-bit alarm comparator flags the tick on which the count becomes equal to a programmed value. A reload-based down-counter, stepped by a separate timer-clock enable, raises a periodic event every P+1 timer ticks.

Software reaches the block through a word-addressed register bus. It has a control word, the count (low and high parts), the alarm (low and high parts), the period, a sticky status word and an interrupt-enable word. The low and high parts of the count can be frozen on their own, and the whole count can be cleared and held at zero. Reading the low part captures the high part into a shadow, so a low-then-high read pair yields one consistent value even when a carry happens between the two reads. Three interrupt lines report rollover, alarm and periodic events.

Top module: `rtc_alarm_timer`

## Requirements
- R1: After reset the count is zero, the alarm is all ones, the period, control, status and interrupt-enable words are zero, and all three interrupt lines are low.
- R2: On each cycle with `tick_en` high, and with no clear and no freeze, the count rises by one, and the low part (address 1) carries into the high part when it is all ones.
- R3: While control bit 1 is set, the count is held at zero. After the bit is cleared, counting resumes from zero.
- R4: Control bit 3 freezes the low part, and no carry reaches the high part while it is set. Control bit 2 freezes only the high part: the low part keeps counting and wraps to zero without a carry.
- R5: A read of address 1 captures the current high part into a shadow. Reads of address 2 return that shadow, so a later carry does not change it.
- R6: When the full count wraps from all ones to zero, status bit 31 is set.
- R7: Status bit 30 is set once when the count becomes equal to {alarm high (address 4), alarm low (address 3)}. The alarm high register keeps only the high-part width of bits.
- R8: With control bit 0 set and control bit 4 clear, status bit 29 is set once every P+1 `tmr_tick` cycles, where P is the period register (address 5). The down-counter reloads P when it reaches zero and on every period write. While it is disabled or frozen, it holds its value.
- R9: Writing 1 to a bit of the status word (address 6) clears that bit. Each interrupt line is its status bit ANDed with the matching bit of the enable word (address 7, bits 31/30/29 for rollover/alarm/periodic).
- R10: Writing an all-zero value to the control word (address 0) clears the whole status word and reloads the periodic counter from P.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | 32.768 kHz count enable, one cycle wide |
| tmr_tick | input | 1 | Timer-clock enable for the periodic counter |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (captures the shadow on address 1) |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq_roll | output | 1 | Rollover interrupt |
| irq_alarm | output | 1 | Alarm interrupt |
| irq_per | output | 1 | Periodic interrupt |

## Verification
The embedded assertions check on every cycle that the count is forced to zero by clear, holds under the low-part freeze and otherwise steps by exactly one. They also check that a wrap, an alarm hit or a periodic fire always reaches its status bit on the next cycle, that an alarm hit lasts a single cycle, and that the periodic counter reloads or holds as required. Only the bench scenarios can show the register-level behaviour: the shadow read staying consistent across a carry, the high-only freeze letting the low part wrap without carry, the exact P+1 spacing of periodic events, write-one-to-clear, enable masking and the all-zero control write.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_CNT_LO = 3'd1,
    A_CNT_HI = 3'd2,
    A_ALM_LO = 3'd3,
    A_ALM_HI = 3'd4,
    A_PERIOD = 3'd5,
    A_STATUS = 3'd6,
    A_IRQ_EN = 3'd7
  } reg_addr_e;

  localparam int CTL_W       = 5;
  localparam int CTL_PER_EN  = 0;
  localparam int CTL_CLR     = 1;
  localparam int CTL_FRZ_HI  = 2;
  localparam int CTL_FRZ_LO  = 3;
  localparam int CTL_FRZ_PER = 4;

  // status / enable word: bit 31 rollover, 30 alarm, 29 periodic
  localparam int EV_N    = 3;
  localparam int EV_LSB  = 29;
  localparam int EV_ROLL = 2;
  localparam int EV_ALM  = 1;
  localparam int EV_PER  = 0;
endpackage

// File: rtl/rtc_counter.sv
module rtc_counter #(
  parameter int LO_W = 32,
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            clr,
  input  logic            frz_lo,
  input  logic            frz_hi,
  output logic [LO_W-1:0] cnt_lo,
  output logic [HI_W-1:0] cnt_hi,
  output logic            wrap
);
  logic [LO_W-1:0] lo_n;
  logic [HI_W-1:0] hi_n;
  logic            lo_step, lo_full, hi_full, carry;

  assign lo_full = &cnt_lo;
  assign hi_full = &cnt_hi;
  assign lo_step = tick && !clr && !frz_lo;
  assign carry   = lo_step && lo_full && !frz_hi;
  assign wrap    = carry && hi_full;

  always_comb begin
    lo_n = cnt_lo;
    hi_n = cnt_hi;
    if (clr) begin
      lo_n = '0;
      hi_n = '0;
    end else begin
      if (lo_step) lo_n = cnt_lo + LO_W'(1);
      if (carry)   hi_n = cnt_hi + HI_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_lo <= '0;
      cnt_hi <= '0;
    end else begin
      cnt_lo <= lo_n;
      cnt_hi <= hi_n;
    end
  end

  // R3: clear forces zero
  a_r3_clear_holds: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_lo == '0 && cnt_hi == '0));
  // R4: low freeze holds the whole count
  a_r4_freeze_lo: assert property (@(posedge clk) disable iff (!rst_n)
    (frz_lo && !clr) |=> ($stable(cnt_lo) && $stable(cnt_hi)));
  // R2: a free tick steps the low part by one
  a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !clr && !frz_lo) |=> (cnt_lo == $past(cnt_lo) + LO_W'(1)));
endmodule

// File: rtl/rtc_alarm.sv
module rtc_alarm #(
  parameter int CNT_W = 40
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] alarm,
  output logic             hit
);
  logic eq, eq_q;

  assign eq  = (cnt == alarm);
  assign hit = eq && !eq_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eq_q <= 1'b0;
    else        eq_q <= eq;
  end

  // R7: one event per arrival at the alarm value
  a_r7_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);
endmodule

// File: rtl/rtc_periodic.sv
module rtc_periodic #(
  parameter int PER_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run,
  input  logic             load,
  input  logic [PER_W-1:0] load_val,
  output logic             fire
);
  logic [PER_W-1:0] dcnt, dcnt_n;
  logic             step;

  assign step = run && tick && !load;
  assign fire = step && (dcnt == '0);

  always_comb begin
    dcnt_n = dcnt;
    if (load)       dcnt_n = load_val;
    else if (fire)  dcnt_n = load_val;
    else if (step)  dcnt_n = dcnt - PER_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dcnt <= '0;
    else        dcnt <= dcnt_n;
  end

  // R8: reload on terminal count or load
  a_r8_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (fire || load) |=> (dcnt == $past(load_val)));
  // R8: disabled or frozen counter holds
  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(dcnt));
endmodule

// File: rtl/rtc_alarm_timer.sv
module rtc_alarm_timer
  import rtc_pkg::*;
#(
  parameter int LO_W  = 32,
  parameter int HI_W  = 8,
  parameter int PER_W = 32
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_en,
  input  logic        tmr_tick,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [2:0]  bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_roll,
  output logic        irq_alarm,
  output logic        irq_per
);
  localparam int CNT_W = LO_W + HI_W;

  logic [CTL_W-1:0] ctrl_q, ctrl_n;
  logic [LO_W-1:0]  alm_lo_q, alm_lo_n;
  logic [HI_W-1:0]  alm_hi_q, alm_hi_n;
  logic [PER_W-1:0] per_q, per_n;
  logic [EV_N-1:0]  st_q, st_n, en_q, en_n, ev_set;
  logic [HI_W-1:0]  shadow_q, shadow_n;

  logic [LO_W-1:0]  cnt_lo;
  logic [HI_W-1:0]  cnt_hi;
  logic             wrap, hit, fire;
  logic             wr_ctrl, wr_per, ctrl_zero, rd_lo;
  logic [PER_W-1:0] reload_val;
  logic             unused_wdata;

  assign unused_wdata = ^bus_wdata;

  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_per     = bus_wr && (bus_addr == A_PERIOD);
  assign ctrl_zero  = wr_ctrl && (bus_wdata[CTL_W-1:0] == '0) && (bus_wdata == 32'd0);
  assign rd_lo      = bus_rd && (bus_addr == A_CNT_LO);
  assign reload_val = wr_per ? bus_wdata[PER_W-1:0] : per_q;

  rtc_counter #(.LO_W(LO_W), .HI_W(HI_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_en),
    .clr    (ctrl_q[CTL_CLR]),
    .frz_lo (ctrl_q[CTL_FRZ_LO]),
    .frz_hi (ctrl_q[CTL_FRZ_HI]),
    .cnt_lo (cnt_lo),
    .cnt_hi (cnt_hi),
    .wrap   (wrap)
  );

  rtc_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk   (clk),
    .rst_n (rst_n),
    .cnt   ({cnt_hi, cnt_lo}),
    .alarm ({alm_hi_q, alm_lo_q}),
    .hit   (hit)
  );

  rtc_periodic #(.PER_W(PER_W)) u_per (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tmr_tick),
    .run      (ctrl_q[CTL_PER_EN] && !ctrl_q[CTL_FRZ_PER]),
    .load     (wr_per || ctrl_zero),
    .load_val (reload_val),
    .fire     (fire)
  );

  always_comb begin
    ev_set          = '0;
    ev_set[EV_ROLL] = wrap;
    ev_set[EV_ALM]  = hit;
    ev_set[EV_PER]  = fire;
  end

  // next-state for the register file
  always_comb begin
    ctrl_n   = ctrl_q;
    alm_lo_n = alm_lo_q;
    alm_hi_n = alm_hi_q;
    per_n    = per_q;
    en_n     = en_q;
    shadow_n = shadow_q;
    st_n     = st_q | ev_set;
    if (bus_wr) begin
      unique case (bus_addr)
        A_CTRL:   begin
          ctrl_n = bus_wdata[CTL_W-1:0];
          if (ctrl_zero) st_n = ev_set;
        end
        A_ALM_LO: alm_lo_n = bus_wdata[LO_W-1:0];
        A_ALM_HI: alm_hi_n = bus_wdata[HI_W-1:0];
        A_PERIOD: per_n    = bus_wdata[PER_W-1:0];
        A_STATUS: st_n     = (st_q & ~bus_wdata[EV_LSB +: EV_N]) | ev_set;
        A_IRQ_EN: en_n     = bus_wdata[EV_LSB +: EV_N];
        default:  ;
      endcase
    end
    if (rd_lo) shadow_n = cnt_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      alm_lo_q <= '1;
      alm_hi_q <= '1;
      per_q    <= '0;
      st_q     <= '0;
      en_q     <= '0;
      shadow_q <= '0;
    end else begin
      ctrl_q   <= ctrl_n;
      alm_lo_q <= alm_lo_n;
      alm_hi_q <= alm_hi_n;
      per_q    <= per_n;
      st_q     <= st_n;
      en_q     <= en_n;
      shadow_q <= shadow_n;
    end
  end

  always_comb begin
    bus_rdata = 32'd0;
    unique case (bus_addr)
      A_CTRL:   bus_rdata = 32'(ctrl_q);
      A_CNT_LO: bus_rdata = 32'(cnt_lo);
      A_CNT_HI: bus_rdata = 32'(shadow_q);
      A_ALM_LO: bus_rdata = 32'(alm_lo_q);
      A_ALM_HI: bus_rdata = 32'(alm_hi_q);
      A_PERIOD: bus_rdata = 32'(per_q);
      A_STATUS: bus_rdata = {st_q, {EV_LSB{1'b0}}};
      A_IRQ_EN: bus_rdata = {en_q, {EV_LSB{1'b0}}};
      default:  bus_rdata = 32'd0;
    endcase
  end

  assign irq_roll  = st_q[EV_ROLL] && en_q[EV_ROLL];
  assign irq_alarm = st_q[EV_ALM]  && en_q[EV_ALM];
  assign irq_per   = st_q[EV_PER]  && en_q[EV_PER];

  // R6: wrap reaches rollover status
  a_r6_roll_sets: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> st_q[EV_ROLL]);
  // R7: alarm hit reaches alarm status
  a_r7_alarm_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> st_q[EV_ALM]);
  // R8: periodic fire reaches periodic status
  a_r8_per_sets: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> st_q[EV_PER]);
  // R10: all-zero control write wipes status absent new events
  a_r10_zero_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_zero && !wrap && !hit && !fire) |=> (st_q == '0));
  // R5: shadow only moves on a low read
  a_r5_shadow_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_lo |=> $stable(shadow_q));
endmodule

// File: tb/test_rtc_alarm_timer.sv
module test_rtc_alarm_timer;
  localparam int CLK_PERIOD = 10;
  localparam int LO_W = 6;
  localparam int HI_W = 3;
  localparam int PER_W = 16;

  logic        clk, rst_n, tick_en, tmr_tick, bus_wr, bus_rd;
  logic [2:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        irq_roll, irq_alarm, irq_per;

  int checks = 0;
  int errors = 0;

  typedef struct { logic [31:0] exp; string tag; } item_t;
  item_t exp_q[$];

  rtc_alarm_timer #(.LO_W(LO_W), .HI_W(HI_W), .PER_W(PER_W)) i_rtc_alarm_timer (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .tmr_tick(tmr_tick),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_roll(irq_roll), .irq_alarm(irq_alarm), .irq_per(irq_per)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // monitor: compares read data against the scoreboard queue
  always @(negedge clk) begin
    if (bus_rd) begin
      item_t it;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual %h expected none", bus_rdata);
      end else begin
        it = exp_q.pop_front();
        checks++;
        if (bus_rdata !== it.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic rd_chk(input logic [2:0] a, input logic [31:0] e, input string tag);
    item_t it;
    it.exp = e; it.tag = tag;
    @(posedge clk); #1;
    exp_q.push_back(it);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(posedge clk); #1;
    tick_en = 1'b1;
    repeat (n) @(posedge clk);
    #1 tick_en = 1'b0;
  endtask

  task automatic tticks(input int n);
    @(posedge clk); #1;
    tmr_tick = 1'b1;
    repeat (n) @(posedge clk);
    #1 tmr_tick = 1'b0;
  endtask

  task automatic irq_chk(input logic [2:0] e, input string tag);
    @(posedge clk);
    @(negedge clk);
    checks++;
    if ({irq_roll, irq_alarm, irq_per} !== e) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, {irq_roll, irq_alarm, irq_per}, e);
    end
  endtask

  initial begin
    rst_n = 1'b0; tick_en = 0; tmr_tick = 0; bus_wr = 0; bus_rd = 0;
    bus_addr = 0; bus_wdata = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    irq_chk(3'b000, "R1 irq after reset");
    rd_chk(3'd0, 32'd0, "R1 ctrl");
    rd_chk(3'd1, 32'd0, "R1 cnt lo");
    rd_chk(3'd2, 32'd0, "R1 cnt hi");
    rd_chk(3'd3, 32'd63, "R1 alarm lo");
    rd_chk(3'd4, 32'd7, "R1 alarm hi");
    rd_chk(3'd5, 32'd0, "R1 period");
    rd_chk(3'd6, 32'd0, "R1 status");

    // R2 counting and carry
    ticks(5);
    rd_chk(3'd1, 32'd5, "R2 lo after 5");
    ticks(60);
    rd_chk(3'd1, 32'd1, "R2 lo after carry");
    rd_chk(3'd2, 32'd1, "R2 hi after carry");

    // R5 coherent read across a carry
    ticks(62);
    rd_chk(3'd1, 32'd63, "R5 lo before carry");
    ticks(1);
    rd_chk(3'd2, 32'd1, "R5 shadow survives carry");
    rd_chk(3'd1, 32'd0, "R5 lo after carry");
    rd_chk(3'd2, 32'd2, "R5 hi refreshed");

    // R3 clear holds at zero
    wr(3'd0, 32'h2);
    ticks(3);
    rd_chk(3'd1, 32'd0, "R3 lo held");
    rd_chk(3'd2, 32'd0, "R3 hi held");
    wr(3'd0, 32'h0);
    ticks(2);
    rd_chk(3'd1, 32'd2, "R3 resume from zero");

    // R4 freezes
    wr(3'd0, 32'h8);
    ticks(4);
    rd_chk(3'd1, 32'd2, "R4 low frozen");
    wr(3'd0, 32'h0);
    ticks(61);
    wr(3'd0, 32'h4);
    ticks(1);
    rd_chk(3'd1, 32'd0, "R4 low wraps under high freeze");
    rd_chk(3'd2, 32'd0, "R4 no carry under high freeze");
    wr(3'd0, 32'h0);

    // R7 alarm
    wr(3'd7, 32'hE000_0000);
    wr(3'd4, 32'hFF);
    rd_chk(3'd4, 32'd7, "R7 alarm hi masked");
    wr(3'd3, 32'd36);
    wr(3'd4, 32'd1);
    ticks(99);
    rd_chk(3'd6, 32'd0, "R7 no alarm before match");
    ticks(1);
    rd_chk(3'd6, 32'h4000_0000, "R7 alarm status");
    irq_chk(3'b010, "R7 alarm irq");
    // R9 write-one-to-clear
    wr(3'd6, 32'h4000_0000);
    rd_chk(3'd6, 32'd0, "R9 w1c status");
    irq_chk(3'b000, "R9 irq drops");

    // R6 rollover
    ticks(411);
    rd_chk(3'd6, 32'd0, "R6 no rollover at all ones");
    ticks(1);
    rd_chk(3'd6, 32'h8000_0000, "R6 rollover status");
    irq_chk(3'b100, "R6 rollover irq");
    wr(3'd6, 32'h8000_0000);

    // R8 periodic
    wr(3'd5, 32'd3);
    wr(3'd0, 32'h1);
    tticks(3);
    rd_chk(3'd6, 32'd0, "R8 no tick before P+1");
    tticks(1);
    rd_chk(3'd6, 32'h2000_0000, "R8 tick at P+1");
    irq_chk(3'b001, "R8 periodic irq");
    wr(3'd6, 32'h2000_0000);
    tticks(4);
    rd_chk(3'd6, 32'h2000_0000, "R8 second period");
    wr(3'd6, 32'h2000_0000);
    wr(3'd0, 32'h11);
    tticks(10);
    rd_chk(3'd6, 32'd0, "R8 frozen holds");
    wr(3'd0, 32'h1);
    tticks(3);
    rd_chk(3'd6, 32'd0, "R8 resume no early tick");
    tticks(1);
    rd_chk(3'd6, 32'h2000_0000, "R8 resume tick");
    // R9 enable masks the line
    wr(3'd7, 32'h0);
    irq_chk(3'b000, "R9 masked irq");
    wr(3'd7, 32'hE000_0000);
    irq_chk(3'b001, "R9 unmasked irq");
    // R10 all-zero control write
    wr(3'd0, 32'h0);
    rd_chk(3'd6, 32'd0, "R10 status wiped");
    tticks(10);
    rd_chk(3'd6, 32'd0, "R8 disabled holds");
    wr(3'd0, 32'h1);
    tticks(2);
    wr(3'd5, 32'd3);
    tticks(3);
    rd_chk(3'd6, 32'd0, "R8 reload on period write");
    tticks(1);
    rd_chk(3'd6, 32'h2000_0000, "R8 tick after reload");
    rd_chk(3'd5, 32'd3, "R8 period readback");

    repeat (3) @(posedge clk);
    if (exp_q.size() != 0) begin
      errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule